// File: doc/BRIEF.md
# Store Set Dependence Predictor

This block decides, as each load or store is dispatched, whether it should wait for an older in-flight store. Program counters are hashed into an identifier table. Each valid entry of that table holds a set number. A second table, indexed by set number, remembers the reorder-buffer tag of the youngest dispatched store of each set that is still in flight. A load in a set that has a live store is told to wait for that store. A load with no set, or with an empty set, may go ahead. A load that keeps violating after it has been placed in a set is marked strict, and from then on it waits for all older stores.

Ordering violations teach the predictor which loads and stores belong together. The identifier table is wiped at a fixed interval, so that pairings which no longer occur are forgotten. The second table loses an entry when the store it names issues or retires. On a partial squash, the second table is rebuilt from the list of stores that survive. The block keeps running counts of predictions by class and of reported violations.

Top module: `store_set_predictor`

## Requirements
- R1: The identifier-table entry for a PC is bits [IDX_W+1:2] of the PC, where IDX_W = log2(SSIT_DEPTH) and SSIT_DEPTH is a power of two. Two PCs that differ by a multiple of 4*SSIT_DEPTH share an entry.
- R2: A dispatched load is predicted Bypass (pred_class 0, pred_tag 0) if its entry has no valid set, or if its set has no live last store.
- R3: On a violation where neither the load PC nor the store PC has a valid set, both entries get set number vl_idx[SID_W-1:0], where vl_idx is the load PC's table index and SID_W = log2(LFST_DEPTH). After that, a store and then a load from those PCs give the load WaitFor (pred_class 1) with pred_tag set to the store's tag.
- R4: On a violation where exactly one PC has a valid set, the other PC's entry joins that set and is not strict.
- R5: On a violation where both PCs have valid sets, the store entry takes the load's set number and the load entry becomes strict. A load whose entry is valid and strict is predicted WaitAll (pred_class 2, pred_tag 0).
- R6: A dispatched store whose entry has a valid set is predicted WaitFor the set's live last store, or Bypass if there is none. It then becomes that set's last store. A store with no set changes no last store. The strict flag is never applied to stores.
- R7: A last-store entry is cleared when issue or retire reports a tag equal to the tag it holds. If this happens in the same cycle as a dispatch that reads that entry, the dispatch already sees the entry as empty. A reported tag that does not match leaves the entry unchanged.
- R8: In a cycle with squash high, dispatch, issue and retire are ignored. The last-store table is cleared and then filled from the valid surviving stores that have a set. A higher list index is younger and wins a shared set.
- R9: The whole identifier table, including the strict flags, is invalidated at every CLEAR_INTERVAL-th clock edge after reset. After that, every PC predicts Bypass until it is learned again.
- R10: Each dispatched load adds one to the counter for its predicted class. Each violation report adds one to cnt_violation, including in squash and clear cycles. Stores change no counter.
- R11: An accepted dispatch gives pred_valid high for exactly one cycle, on the clock edge after it is presented. With no accepted dispatch, pred_valid, pred_class and pred_tag are 0. The prediction is taken from the tables as they were before that edge.
- R12: After reset, pred_valid, pred_class, pred_tag and all counters are 0. Every table entry is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | A memory operation is dispatched this cycle |
| disp_is_load | input | 1 | 1 = load, 0 = store |
| disp_pc | input | PC_W | PC of the dispatched operation |
| disp_tag | input | TAG_W | Reorder-buffer tag of the dispatched operation |
| issue_valid | input | 1 | A store has issued |
| issue_tag | input | TAG_W | Tag of the issued store |
| retire_valid | input | 1 | A store has retired |
| retire_tag | input | TAG_W | Tag of the retired store |
| viol_valid | input | 1 | An ordering violation is reported |
| viol_load_pc | input | PC_W | PC of the violating load |
| viol_store_pc | input | PC_W | PC of the store the load bypassed |
| squash | input | 1 | Partial pipeline squash |
| surv_valid | input | SQ_N | Valid bit for each surviving-store slot |
| surv_pc | input | SQ_N*PC_W | PC of each surviving store, slot 0 oldest |
| surv_tag | input | SQ_N*TAG_W | Tag of each surviving store |
| pred_valid | output | 1 | A prediction is presented |
| pred_class | output | 2 | 0 Bypass, 1 WaitFor, 2 WaitAll |
| pred_tag | output | TAG_W | Store tag to wait for when pred_class is 1, else 0 |
| cnt_bypass | output | CNT_W | Loads predicted Bypass |
| cnt_wait_for | output | CNT_W | Loads predicted WaitFor |
| cnt_wait_all | output | CNT_W | Loads predicted WaitAll |
| cnt_violation | output | CNT_W | Violation reports received |

## Verification
The assertions take the control inputs (disp_valid, disp_is_load, squash, viol_valid) to be known from the first edge after reset. They also take every counter to stay below its wrap point, so that each report or load moves one counter by exactly one. The stimulus drives every input to 0 during reset and holds them at defined values afterwards. It runs for a few thousand cycles, well under the 16-bit counter range. Tags are drawn from a small range so that issue and retire reports really do hit last-store entries. Violations, squashes and dispatches also overlap in the same cycle.

// File: rtl/store_set_predictor.sv
module store_set_predictor #(
  parameter int PC_W           = 32,
  parameter int TAG_W          = 8,
  parameter int SSIT_DEPTH     = 2048,
  parameter int LFST_DEPTH     = 256,
  parameter int CLEAR_INTERVAL = 100000,
  parameter int SQ_N           = 8,
  parameter int CNT_W          = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       disp_valid,
  input  logic                       disp_is_load,
  input  logic [PC_W-1:0]            disp_pc,
  input  logic [TAG_W-1:0]           disp_tag,
  input  logic                       issue_valid,
  input  logic [TAG_W-1:0]           issue_tag,
  input  logic                       retire_valid,
  input  logic [TAG_W-1:0]           retire_tag,
  input  logic                       viol_valid,
  input  logic [PC_W-1:0]            viol_load_pc,
  input  logic [PC_W-1:0]            viol_store_pc,
  input  logic                       squash,
  input  logic [SQ_N-1:0]            surv_valid,
  input  logic [SQ_N-1:0][PC_W-1:0]  surv_pc,
  input  logic [SQ_N-1:0][TAG_W-1:0] surv_tag,
  output logic                       pred_valid,
  output logic [1:0]                 pred_class,
  output logic [TAG_W-1:0]           pred_tag,
  output logic [CNT_W-1:0]           cnt_bypass,
  output logic [CNT_W-1:0]           cnt_wait_for,
  output logic [CNT_W-1:0]           cnt_wait_all,
  output logic [CNT_W-1:0]           cnt_violation
);
  localparam int IDX_W = $clog2(SSIT_DEPTH);
  localparam int SID_W = $clog2(LFST_DEPTH);
  localparam int CLR_W = $clog2(CLEAR_INTERVAL + 1);
  localparam logic [1:0] CLS_BYPASS   = 2'd0;
  localparam logic [1:0] CLS_WAIT_FOR = 2'd1;
  localparam logic [1:0] CLS_WAIT_ALL = 2'd2;

  logic [SSIT_DEPTH-1:0] ss_v, ss_strict;
  logic [SID_W-1:0]      ss_id [SSIT_DEPTH];
  logic [LFST_DEPTH-1:0] lf_v, lf_kill, lf_live;
  logic [TAG_W-1:0]      lf_tag [LFST_DEPTH];
  logic [CLR_W-1:0]      clr_cnt;

  logic [IDX_W-1:0] d_idx, vl_idx, vs_idx;
  logic [IDX_W-1:0] sv_idx [SQ_N];
  logic [SID_W-1:0] d_sid, vl_sid, vs_sid;
  logic             d_hit, d_strict, d_prev_v, vl_hit, vs_hit, accept, clear_now;
  logic [1:0]       nxt_class;

  assign d_idx    = disp_pc[IDX_W+1:2];
  assign vl_idx   = viol_load_pc[IDX_W+1:2];
  assign vs_idx   = viol_store_pc[IDX_W+1:2];
  assign d_hit    = ss_v[d_idx];
  assign d_strict = ss_strict[d_idx];
  assign d_sid    = ss_id[d_idx];
  assign vl_hit   = ss_v[vl_idx];
  assign vs_hit   = ss_v[vs_idx];
  assign vl_sid   = ss_id[vl_idx];
  assign vs_sid   = ss_id[vs_idx];
  assign accept   = disp_valid && !squash;
  assign clear_now = (clr_cnt == CLR_W'(CLEAR_INTERVAL - 1));

  for (genvar g = 0; g < SQ_N; g++) begin : g_surv
    assign sv_idx[g] = surv_pc[g][IDX_W+1:2];
  end

  for (genvar g = 0; g < LFST_DEPTH; g++) begin : g_kill
    assign lf_kill[g] = (issue_valid && lf_tag[g] == issue_tag) ||
                        (retire_valid && lf_tag[g] == retire_tag);
  end
  assign lf_live  = lf_v & ~lf_kill;
  assign d_prev_v = lf_live[d_sid];

  always_comb begin
    nxt_class = CLS_BYPASS;
    if (d_hit) begin
      if (disp_is_load && d_strict) nxt_class = CLS_WAIT_ALL;
      else if (d_prev_v)            nxt_class = CLS_WAIT_FOR;
    end
  end

  // identifier table: periodic wipe, learning from violations
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ss_v      <= '0;
      ss_strict <= '0;
      clr_cnt   <= '0;
    end else begin
      clr_cnt <= clear_now ? '0 : clr_cnt + 1'b1;
      if (clear_now) begin
        ss_v      <= '0;
        ss_strict <= '0;
      end else if (viol_valid) begin
        if (!vl_hit && !vs_hit) begin
          ss_v[vs_idx] <= 1'b1; ss_strict[vs_idx] <= 1'b0; ss_id[vs_idx] <= vl_idx[SID_W-1:0];
          ss_v[vl_idx] <= 1'b1; ss_strict[vl_idx] <= 1'b0; ss_id[vl_idx] <= vl_idx[SID_W-1:0];
        end else if (vl_hit && !vs_hit) begin
          ss_v[vs_idx] <= 1'b1; ss_strict[vs_idx] <= 1'b0; ss_id[vs_idx] <= vl_sid;
        end else if (!vl_hit && vs_hit) begin
          ss_v[vl_idx] <= 1'b1; ss_strict[vl_idx] <= 1'b0; ss_id[vl_idx] <= vs_sid;
        end else begin
          ss_id[vs_idx]     <= vl_sid;
          ss_strict[vl_idx] <= 1'b1;
        end
      end
    end
  end

  // last-store table: rebuild on squash, else invalidate and record stores
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lf_v <= '0;
    end else if (squash) begin
      lf_v <= '0;
      for (int i = 0; i < SQ_N; i++) begin
        if (surv_valid[i] && ss_v[sv_idx[i]]) begin
          lf_v[ss_id[sv_idx[i]]]   <= 1'b1;
          lf_tag[ss_id[sv_idx[i]]] <= surv_tag[i];
        end
      end
    end else begin
      lf_v <= lf_live;
      if (accept && !disp_is_load && d_hit) begin
        lf_v[d_sid]   <= 1'b1;
        lf_tag[d_sid] <= disp_tag;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pred_valid    <= 1'b0;
      pred_class    <= CLS_BYPASS;
      pred_tag      <= '0;
      cnt_bypass    <= '0;
      cnt_wait_for  <= '0;
      cnt_wait_all  <= '0;
      cnt_violation <= '0;
    end else begin
      pred_valid <= accept;
      pred_class <= accept ? nxt_class : CLS_BYPASS;
      pred_tag   <= (accept && nxt_class == CLS_WAIT_FOR) ? lf_tag[d_sid] : '0;
      if (viol_valid) cnt_violation <= cnt_violation + 1'b1;
      if (accept && disp_is_load) begin
        case (nxt_class)
          CLS_WAIT_FOR: cnt_wait_for <= cnt_wait_for + 1'b1;
          CLS_WAIT_ALL: cnt_wait_all <= cnt_wait_all + 1'b1;
          default:      cnt_bypass   <= cnt_bypass + 1'b1;
        endcase
      end
    end
  end
endmodule

// File: rtl/store_set_predictor_checker.sv
module store_set_predictor_checker #(
  parameter int TAG_W = 8,
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             disp_valid,
  input logic             disp_is_load,
  input logic             squash,
  input logic             viol_valid,
  input logic             pred_valid,
  input logic [1:0]       pred_class,
  input logic [TAG_W-1:0] pred_tag,
  input logic [CNT_W-1:0] cnt_bypass,
  input logic [CNT_W-1:0] cnt_wait_for,
  input logic [CNT_W-1:0] cnt_wait_all,
  input logic [CNT_W-1:0] cnt_violation
);
  logic [CNT_W-1:0] pred_sum;
  assign pred_sum = cnt_bypass + cnt_wait_for + cnt_wait_all;

  p_pred_follows_dispatch_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && !squash) |=> pred_valid);
  p_idle_no_pred_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_valid |=> (!pred_valid && pred_class == 2'd0 && pred_tag == '0));
  p_squash_drops_dispatch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    squash |=> !pred_valid);
  p_class_legal_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pred_valid |-> pred_class != 2'd3);
  p_tag_only_waitfor_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_valid && pred_class != 2'd1) |-> pred_tag == '0);
  p_viol_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
    viol_valid |=> cnt_violation == $past(cnt_violation) + 1'b1);
  p_viol_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !viol_valid |=> $stable(cnt_violation));
  p_load_counted_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && disp_is_load && !squash) |=> pred_sum == $past(pred_sum) + 1'b1);
  p_store_not_counted_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(disp_valid && disp_is_load && !squash) |=> $stable(pred_sum));
endmodule

bind store_set_predictor store_set_predictor_checker #(.TAG_W(TAG_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_is_load(disp_is_load),
  .squash(squash), .viol_valid(viol_valid), .pred_valid(pred_valid),
  .pred_class(pred_class), .pred_tag(pred_tag), .cnt_bypass(cnt_bypass),
  .cnt_wait_for(cnt_wait_for), .cnt_wait_all(cnt_wait_all), .cnt_violation(cnt_violation)
);

// File: tb/store_set_predictor_tb.sv
module store_set_predictor_tb;
  localparam int PC_W = 32, TAG_W = 6, SSIT = 64, LFST = 16, CLR = 300, SQN = 4, CNTW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic disp_valid, disp_is_load, issue_valid, retire_valid, viol_valid, squash;
  logic [PC_W-1:0] disp_pc, viol_load_pc, viol_store_pc;
  logic [TAG_W-1:0] disp_tag, issue_tag, retire_tag;
  logic [SQN-1:0] surv_valid;
  logic [SQN-1:0][PC_W-1:0] surv_pc;
  logic [SQN-1:0][TAG_W-1:0] surv_tag;
  logic pred_valid;
  logic [1:0] pred_class;
  logic [TAG_W-1:0] pred_tag;
  logic [CNTW-1:0] cnt_bypass, cnt_wait_for, cnt_wait_all, cnt_violation;

  always #4 clk = ~clk;

  store_set_predictor #(.PC_W(PC_W), .TAG_W(TAG_W), .SSIT_DEPTH(SSIT), .LFST_DEPTH(LFST),
    .CLEAR_INTERVAL(CLR), .SQ_N(SQN), .CNT_W(CNTW)) u_dut (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  // behavioural reference state
  int m_sv[SSIT], m_sid[SSIT], m_st[SSIT], m_lv[LFST], m_lt[LFST];
  int m_clr = 0, m_byp = 0, m_wf = 0, m_wa = 0, m_viol = 0;
  int e_valid, e_class, e_tag;
  string e_req;

  function automatic int idx(logic [PC_W-1:0] pc);
    return int'((pc >> 2) % SSIT);
  endfunction

  function automatic bit live(int s);
    return m_lv[s] != 0 && !(issue_valid && m_lt[s] == int'(issue_tag)) &&
           !(retire_valid && m_lt[s] == int'(retire_tag));
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_step();
    bit acc;
    acc = disp_valid && !squash;
    e_valid = acc; e_class = 0; e_tag = 0;
    e_req = squash ? "R8" : "R11";
    if (acc) begin
      int di = idx(disp_pc);
      if (m_sv[di] == 0) e_req = "R2";
      else begin
        int s = m_sid[di];
        if (disp_is_load && m_st[di] != 0) begin e_class = 2; e_req = "R5"; end
        else if (live(s)) begin e_class = 1; e_tag = m_lt[s]; e_req = disp_is_load ? "R3" : "R6"; end
        else e_req = disp_is_load ? "R2" : "R6";
      end
      if (disp_is_load) begin
        if (e_class == 0) m_byp++; else if (e_class == 1) m_wf++; else m_wa++;
      end
    end
    if (viol_valid) m_viol++;
    if (squash) begin
      for (int s = 0; s < LFST; s++) m_lv[s] = 0;
      for (int i = 0; i < SQN; i++)
        if (surv_valid[i] && m_sv[idx(surv_pc[i])] != 0) begin
          m_lv[m_sid[idx(surv_pc[i])]] = 1;
          m_lt[m_sid[idx(surv_pc[i])]] = int'(surv_tag[i]);
        end
    end else begin
      for (int s = 0; s < LFST; s++) if (!live(s)) m_lv[s] = 0;
      if (acc && !disp_is_load && m_sv[idx(disp_pc)] != 0) begin
        m_lv[m_sid[idx(disp_pc)]] = 1;
        m_lt[m_sid[idx(disp_pc)]] = int'(disp_tag);
      end
    end
    if (m_clr == CLR - 1) begin
      m_clr = 0;
      for (int k = 0; k < SSIT; k++) begin m_sv[k] = 0; m_st[k] = 0; end
    end else begin
      m_clr++;
      if (viol_valid) begin
        int li = idx(viol_load_pc), si = idx(viol_store_pc);
        bit lh = m_sv[li] != 0, sh = m_sv[si] != 0;
        int lsid = m_sid[li], ssid = m_sid[si];
        if (!lh && !sh) begin
          m_sv[si] = 1; m_st[si] = 0; m_sid[si] = li % LFST;
          m_sv[li] = 1; m_st[li] = 0; m_sid[li] = li % LFST;
        end else if (lh && !sh) begin
          m_sv[si] = 1; m_st[si] = 0; m_sid[si] = lsid;
        end else if (!lh && sh) begin
          m_sv[li] = 1; m_st[li] = 0; m_sid[li] = ssid;
        end else begin
          m_sid[si] = lsid; m_st[li] = 1;
        end
      end
    end
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    chk("R11", "pred_valid", int'(pred_valid), e_valid);
    chk(e_req, "pred_class", int'(pred_class), e_class);
    chk(e_req, "pred_tag", int'(pred_tag), e_tag);
    chk("R10", "cnt_bypass", int'(cnt_bypass), m_byp % 65536);
    chk("R10", "cnt_wait_for", int'(cnt_wait_for), m_wf % 65536);
    chk("R10", "cnt_wait_all", int'(cnt_wait_all), m_wa % 65536);
    chk("R10", "cnt_violation", int'(cnt_violation), m_viol % 65536);
  endtask

  task automatic clear_in();
    disp_valid = 0; disp_is_load = 0; disp_pc = '0; disp_tag = '0;
    issue_valid = 0; issue_tag = '0; retire_valid = 0; retire_tag = '0;
    viol_valid = 0; viol_load_pc = '0; viol_store_pc = '0;
    squash = 0; surv_valid = '0; surv_pc = '0; surv_tag = '0;
  endtask

  task automatic disp(bit ld, logic [PC_W-1:0] pc, int tag);
    disp_valid = 1; disp_is_load = ld; disp_pc = pc; disp_tag = TAG_W'(tag);
  endtask

  task automatic viol(logic [PC_W-1:0] lpc, logic [PC_W-1:0] spc);
    viol_valid = 1; viol_load_pc = lpc; viol_store_pc = spc;
  endtask

  task automatic step_expect(string req, int cls, int tag);
    tick();
    chk(req, "directed valid", int'(pred_valid), 1);
    chk(req, "directed class", int'(pred_class), cls);
    chk(req, "directed tag", int'(pred_tag), tag);
    clear_in();
  endtask

  task automatic step();
    tick();
    clear_in();
  endtask

  localparam logic [31:0] LD_A = 32'h104, ST_A = 32'h208, ST_ALIAS = 32'h308, LD_B = 32'h30C;

  initial begin
    for (int k = 0; k < SSIT; k++) begin m_sv[k] = 0; m_sid[k] = 0; m_st[k] = 0; end
    for (int s = 0; s < LFST; s++) begin m_lv[s] = 0; m_lt[s] = 0; end
    clear_in();
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R12 reset state
    chk("R12", "reset pred_valid", int'(pred_valid), 0);
    chk("R12", "reset pred_tag", int'(pred_tag), 0);
    chk("R12", "reset counters", int'(cnt_bypass) + int'(cnt_wait_for) + int'(cnt_wait_all) + int'(cnt_violation), 0);

    disp(1, LD_A, 1);  step_expect("R2", 0, 0);
    viol(LD_A, ST_A);  step();
    disp(0, ST_A, 5);  step_expect("R6", 0, 0);
    disp(1, LD_A, 6);  step_expect("R3", 1, 5);
    disp(0, ST_ALIAS, 7); step_expect("R1", 1, 5);
    disp(1, LD_A, 8);  step_expect("R1", 1, 7);
    // R7 same-cycle issue hides the entry
    disp(1, LD_A, 9); issue_valid = 1; issue_tag = 6'd7; step_expect("R7", 0, 0);
    disp(1, LD_A, 11); step_expect("R7", 0, 0);
    disp(0, ST_A, 10); step_expect("R6", 0, 0);
    disp(1, LD_A, 12); retire_valid = 1; retire_tag = 6'd5; step_expect("R7", 1, 10);
    // R4 load joins the store's set
    viol(LD_B, ST_A);  step();
    disp(1, LD_B, 13); step_expect("R4", 1, 10);
    // R5 repeated violation makes the load strict
    viol(LD_A, ST_A);  step();
    chk("R10", "three violations", int'(cnt_violation), 3);
    disp(1, LD_A, 14); step_expect("R5", 2, 0);
    disp(1, LD_B, 15); step_expect("R5", 1, 10);
    // R8 squash rebuild, later slot wins
    squash = 1; disp(1, LD_A, 16);
    surv_valid = 4'b1011;
    surv_pc[0] = ST_A; surv_tag[0] = 6'd20;
    surv_pc[1] = ST_ALIAS; surv_tag[1] = 6'd21;
    surv_pc[3] = 32'h7F0; surv_tag[3] = 6'd22;
    step();
    chk("R8", "squash dispatch dropped", int'(pred_valid), 0);
    disp(1, LD_B, 17); step_expect("R8", 1, 21);
    squash = 1; step();
    disp(1, LD_B, 18); step_expect("R8", 0, 0);
    // R9 periodic wipe
    disp(0, ST_A, 30); step_expect("R6", 0, 0);
    disp(1, LD_B, 31); step_expect("R9", 1, 30);
    repeat (CLR) step();
    disp(1, LD_B, 32); step_expect("R9", 0, 0);

    // mixed traffic against the reference model
    for (int n = 0; n < 2500; n++) begin
      logic [31:0] pool [8] = '{32'h104, 32'h208, 32'h30C, 32'h410, 32'h308, 32'h514, 32'h618, 32'h71C};
      if ($urandom_range(0, 9) < 6) disp($urandom_range(0, 1) == 1, pool[$urandom_range(0, 7)], $urandom_range(0, 15));
      if ($urandom_range(0, 9) < 2) begin issue_valid = 1; issue_tag = TAG_W'($urandom_range(0, 15)); end
      if ($urandom_range(0, 9) < 2) begin retire_valid = 1; retire_tag = TAG_W'($urandom_range(0, 15)); end
      if ($urandom_range(0, 99) < 5) viol(pool[$urandom_range(0, 7)], pool[$urandom_range(0, 7)]);
      if ($urandom_range(0, 99) < 3) begin
        squash = 1;
        for (int i = 0; i < SQN; i++) begin
          surv_valid[i] = $urandom_range(0, 1) == 1;
          surv_pc[i] = pool[$urandom_range(0, 7)];
          surv_tag[i] = TAG_W'($urandom_range(0, 15));
        end
      end
      step();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule